// File: doc/BRIEF.md
# Synchronous Serial Master/Slave Engine

This core moves words between a pair of word queues and a four-wire synchronous serial link. It can drive the link as the clock source (master) or follow a clock and frame supplied from outside (slave). The `isMaster` input picks the role. Outgoing words come from a transmit queue through a pop/available handshake. Each received word is pushed out with a one-cycle strobe. The queues themselves, the register interface and the bit-rate divider are not part of this block. In master mode the serial clock advances only on the `bitTick` enable pulse, and each pulse is one half period of the serial clock.

Every word is preceded by a frame marker. The marker is one serial-clock period long and spans the rising edge just before the most significant bit. Word length is programmable from 4 to 16 bits, and bits always travel most significant first. In slave mode the incoming clock, frame and data pass through a two-stage synchronizer, and edges are detected in the system clock domain. For that reason the incoming bit rate must not exceed one twelfth of the system clock. `isMaster` and `frameLen` are expected to change only while the link is idle.

Top module: `ssp_engine`

## Requirements
- R1: `frameLen` holds word length minus one. Values 3 to 15 give 4 to 16 bits, and any value below 3 is treated as 3, giving 4 bits.
- R2: Bits are shifted most significant first. A word of N bits occupies bits N-1..0 of `txWord`, and any bits above N-1 are never transmitted.
- R3: As master, `frmOut` is high for exactly one serial-clock period. That period contains one rising edge of `sclkOut`, and the first data bit follows it. `frmOut` only rises while `sclkOut` is low.
- R4: As master, a word starts only when `txAvail` is high. With the queue empty, `sclkOut`, `frmOut` and `txOe` stay low and no pop occurs.
- R5: Transmit data changes only on a falling serial-clock edge, and received data is taken on a rising edge.
- R6: `ctlOe` is high in master mode and low in slave mode. In slave mode `sclkOut` and `frmOut` stay low.
- R7: `txOe` goes high when the most significant bit is launched and falls at the falling edge after the last bit. While `txOe` is low, `txd` is 0.
- R8: As slave, a rising edge of `sclkIn` seen with `frmIn` high starts a word. The word is taken from the transmit queue if `txAvail` is high. Otherwise all zeros are sent and no pop occurs.
- R9: After the last bit of a word is sampled, `rxPush` pulses for one cycle. At that point `rxWord` holds the received word right-aligned, with zeros above it.
- R10: In master mode `sclkOut` changes only in a cycle after `bitTick` was high.
- R11: `txPop` is high for one cycle per word, only when `txAvail` is high, at the start of the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| isMaster | input | 1 | 1 selects master role, 0 slave role |
| frameLen | input | 4 | Word length minus one |
| bitTick | input | 1 | Half-period enable for the master serial clock |
| txWord | input | 16 | Head of the transmit queue, right-aligned |
| txAvail | input | 1 | Transmit queue holds at least one word |
| txPop | output | 1 | Removes the head of the transmit queue |
| rxWord | output | 16 | Received word, right-aligned |
| rxPush | output | 1 | `rxWord` is valid for one cycle |
| sclkIn | input | 1 | Serial clock from an external master |
| frmIn | input | 1 | Frame marker from an external master |
| rxdIn | input | 1 | Serial data input |
| sclkOut | output | 1 | Serial clock driven as master |
| frmOut | output | 1 | Frame marker driven as master |
| ctlOe | output | 1 | Output enable shared by `sclkOut` and `frmOut` |
| txd | output | 1 | Serial data output |
| txOe | output | 1 | Output enable for `txd` |

## Verification
The bench builds the core with its default 16-bit word width and a two-stage synchronizer. With these values it can run full 16-bit words and the 4-bit minimum, including a clamped length code, a right-aligned word with junk in its upper bits, and a back-to-back pair. Master runs use a tick every cycle, which gives the fastest serial clock of two system cycles per bit, and also a slower tick. Slave runs use a 12-cycle bit period, the fastest rate the synchronizer permits, both with a queued reply word and with an empty queue.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  // Strobes issued by the control FSM to the datapath.
  typedef struct packed {
    logic load;      // capture next transmit word, arm bit counter
    logic launch;    // start driving the data line
    logic shiftTx;   // present the next transmit bit
    logic sampleRx;  // take one received bit
    logic dropOe;    // stop driving the data line
  } sspStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_DATA = 2'd2
  } sspState_t;

endpackage

// File: rtl/ssp_datapath.sv
module ssp_datapath
  import ssp_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int LEN_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              isMaster,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic [DATA_W-1:0] txWord,
  input  logic              txAvail,
  input  logic              sclkIn,
  input  logic              frmIn,
  input  logic              rxdIn,
  input  sspStrobe_t        strb,
  output logic              sRise,
  output logic              sFall,
  output logic              sFrm,
  output logic              cntZero,
  output logic              txd,
  output logic              txOe,
  output logic [DATA_W-1:0] rxWord,
  output logic              rxPush
);

  localparam int          MIN_BITS = 4;
  localparam logic [LEN_W-1:0] MIN_CODE = LEN_W'(MIN_BITS - 1);

  // Synchronizer chain for {clock, frame, data} of the slave side.
  logic [2:0] syncQ [SYNC_STAGES];

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ[g] <= '0;
      end else if (g == 0) begin
        syncQ[g] <= {sclkIn, frmIn, rxdIn};
      end else begin
        syncQ[g] <= syncQ[(g == 0) ? 0 : g - 1];
      end
    end
  end

  logic sclkSync, rxdSync, sclkPrev;
  assign sclkSync = syncQ[SYNC_STAGES-1][2];
  assign sFrm     = syncQ[SYNC_STAGES-1][1];
  assign rxdSync  = syncQ[SYNC_STAGES-1][0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= sclkSync;
  end

  assign sRise = sclkSync & ~sclkPrev;
  assign sFall = ~sclkSync & sclkPrev;

  // Effective length code, clamped to the minimum word size.
  logic [LEN_W-1:0] lenCode;
  assign lenCode = (frameLen < MIN_CODE) ? MIN_CODE : frameLen;

  logic [DATA_W-1:0] txShift, rxShift;
  logic [LEN_W-1:0]  bitCnt;
  logic              oeReg, pushReg;
  logic              rxBit;

  assign rxBit = isMaster ? rxdIn : rxdSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      bitCnt  <= '0;
      oeReg   <= 1'b0;
      pushReg <= 1'b0;
    end else begin
      pushReg <= strb.sampleRx & cntZero;
      if (strb.load) begin
        txShift <= txAvail ? txWord : '0;
        rxShift <= '0;
        bitCnt  <= lenCode;
      end
      if (strb.launch)  oeReg   <= 1'b1;
      if (strb.shiftTx) txShift <= {txShift[DATA_W-2:0], 1'b0};
      if (strb.sampleRx) begin
        rxShift <= {rxShift[DATA_W-2:0], rxBit};
        if (!cntZero) bitCnt <= bitCnt - 1'b1;
      end
      if (strb.dropOe)  oeReg   <= 1'b0;
    end
  end

  assign cntZero = (bitCnt == '0);
  assign txd     = oeReg & txShift[lenCode];
  assign txOe    = oeReg;
  assign rxWord  = rxShift;
  assign rxPush  = pushReg;

endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       isMaster,
  input  logic       bitTick,
  input  logic       txAvail,
  input  logic       sRise,
  input  logic       sFall,
  input  logic       sFrm,
  input  logic       cntZero,
  output sspStrobe_t strb,
  output logic       txPop,
  output logic       sclkOut,
  output logic       frmOut
);

  sspState_t state;
  logic      doneReg, sclkReg, frmReg;
  logic      mStart, mRise, mFall;
  logic      rise, fall, frameAtRise;

  // Master-side serial clock events, one per bitTick.
  assign mStart = isMaster & bitTick & ~sclkReg & ~frmReg &
                  (state == ST_IDLE) & txAvail;
  assign mRise  = isMaster & bitTick & ~sclkReg &
                  ((state != ST_IDLE) | frmReg);
  assign mFall  = isMaster & bitTick & sclkReg;

  assign rise        = isMaster ? mRise  : sRise;
  assign fall        = isMaster ? mFall  : sFall;
  assign frameAtRise = isMaster ? frmReg : sFrm;

  always_comb begin
    strb  = '0;
    txPop = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (rise && frameAtRise) begin
          strb.load = 1'b1;
          txPop     = txAvail;
        end
      end
      ST_ARM: begin
        if (fall) strb.launch = 1'b1;
      end
      ST_DATA: begin
        if (rise) begin
          strb.sampleRx = 1'b1;
        end else if (fall) begin
          if (doneReg) strb.dropOe  = 1'b1;
          else         strb.shiftTx = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      doneReg <= 1'b0;
    end else begin
      if (strb.load)                state   <= ST_ARM;
      if (strb.launch)              state   <= ST_DATA;
      if (strb.dropOe)              state   <= ST_IDLE;
      if (strb.load)                doneReg <= 1'b0;
      if (strb.sampleRx && cntZero) doneReg <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkReg <= 1'b0;
      frmReg  <= 1'b0;
    end else if (!isMaster) begin
      sclkReg <= 1'b0;
      frmReg  <= 1'b0;
    end else begin
      if (mStart) frmReg  <= 1'b1;
      if (mRise)  sclkReg <= 1'b1;
      if (mFall) begin
        sclkReg <= 1'b0;
        frmReg  <= 1'b0;
      end
    end
  end

  assign sclkOut = sclkReg;
  assign frmOut  = frmReg;

endmodule

// File: rtl/ssp_engine.sv
module ssp_engine
  import ssp_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int LEN_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              isMaster,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic              bitTick,
  input  logic [DATA_W-1:0] txWord,
  input  logic              txAvail,
  output logic              txPop,
  output logic [DATA_W-1:0] rxWord,
  output logic              rxPush,
  input  logic              sclkIn,
  input  logic              frmIn,
  input  logic              rxdIn,
  output logic              sclkOut,
  output logic              frmOut,
  output logic              ctlOe,
  output logic              txd,
  output logic              txOe
);

  sspStrobe_t strb;
  logic       sRise, sFall, sFrm, cntZero;

  ssp_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .isMaster (isMaster),
    .bitTick  (bitTick),
    .txAvail  (txAvail),
    .sRise    (sRise),
    .sFall    (sFall),
    .sFrm     (sFrm),
    .cntZero  (cntZero),
    .strb     (strb),
    .txPop    (txPop),
    .sclkOut  (sclkOut),
    .frmOut   (frmOut)
  );

  ssp_datapath #(
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .isMaster (isMaster),
    .frameLen (frameLen),
    .txWord   (txWord),
    .txAvail  (txAvail),
    .sclkIn   (sclkIn),
    .frmIn    (frmIn),
    .rxdIn    (rxdIn),
    .strb     (strb),
    .sRise    (sRise),
    .sFall    (sFall),
    .sFrm     (sFrm),
    .cntZero  (cntZero),
    .txd      (txd),
    .txOe     (txOe),
    .rxWord   (rxWord),
    .rxPush   (rxPush)
  );

  assign ctlOe = isMaster;

endmodule

// File: rtl/ssp_engine_chk.sv
module ssp_engine_chk (
  input logic clk,
  input logic rstN,
  input logic isMaster,
  input logic bitTick,
  input logic txAvail,
  input logic txPop,
  input logic sclkOut,
  input logic frmOut,
  input logic ctlOe,
  input logic txd,
  input logic txOe
);

  // R11
  pop_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    txPop |-> txAvail);

  // R10
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && !bitTick) |=> (!isMaster || $stable(sclkOut)));

  // R5
  launch_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && txOe && $past(txOe) && !$stable(txd)) |-> $fell(sclkOut));

  // R3
  frame_low_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frmOut) |-> !sclkOut);

  // R6
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !isMaster |-> (!ctlOe && !sclkOut && !frmOut));

  // R7
  idle_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txOe |-> !txd);

endmodule

bind ssp_engine ssp_engine_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .isMaster (isMaster),
  .bitTick  (bitTick),
  .txAvail  (txAvail),
  .txPop    (txPop),
  .sclkOut  (sclkOut),
  .frmOut   (frmOut),
  .ctlOe    (ctlOe),
  .txd      (txd),
  .txOe     (txOe)
);

// File: tb/ssp_engine_tb.sv
`timescale 1ns/1ps
module ssp_engine_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        isMaster = 1'b1;
  logic [3:0]  frameLen = 4'd15;
  logic        bitTick;
  logic [15:0] txWord;
  logic        txAvail;
  logic        txPop;
  logic [15:0] rxWord;
  logic        rxPush;
  logic        sclkIn = 1'b0, frmIn = 1'b0, sRxd = 1'b0;
  logic        rxdIn;
  logic        sclkOut, frmOut, ctlOe, txd, txOe;

  int testsRun = 0, testsFailed = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  // Queue models and serial monitor.
  logic [15:0] txQ [8];
  logic [15:0] rxQ [8];
  logic        logBit [256];
  logic        logFrm [256];
  int  txCnt = 0, txIdx = 0, rxCnt = 0, logN = 0;
  logic clrQ = 1'b0;
  logic sclkSeen = 1'b0;
  int  tickDiv = 1, tickCnt = 0;
  logic tickEn = 1'b0;

  assign txAvail = (txIdx < txCnt);
  assign txWord  = txQ[txIdx[2:0]];
  assign rxdIn   = isMaster ? txd : sRxd;

  always @(posedge clk) begin
    if (clrQ) txIdx <= 0;
    else if (txPop) txIdx <= txIdx + 1;
  end

  always @(posedge clk) begin
    if (!tickEn) begin
      tickCnt <= 0; bitTick <= 1'b0;
    end else if (tickCnt >= tickDiv - 1) begin
      tickCnt <= 0; bitTick <= 1'b1;
    end else begin
      tickCnt <= tickCnt + 1; bitTick <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (clrQ) begin
      rxCnt <= 0; logN <= 0;
    end else begin
      if (rxPush) begin
        rxQ[rxCnt[2:0]] <= rxWord;
        rxCnt <= rxCnt + 1;
      end
      if (sclkOut && !sclkSeen) begin
        logBit[logN[7:0]] <= txd;
        logFrm[logN[7:0]] <= frmOut;
        logN <= logN + 1;
      end
    end
    sclkSeen <= sclkOut;
  end

  ssp_engine u_dut (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .frameLen(frameLen),
    .bitTick(bitTick), .txWord(txWord), .txAvail(txAvail), .txPop(txPop),
    .rxWord(rxWord), .rxPush(rxPush), .sclkIn(sclkIn), .frmIn(frmIn),
    .rxdIn(rxdIn), .sclkOut(sclkOut), .frmOut(frmOut), .ctlOe(ctlOe),
    .txd(txd), .txOe(txOe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int bitsOf(input logic [3:0] code);
    return (code < 4'd3) ? 4 : int'(code) + 1;
  endfunction

  task automatic clearQueues();
    @(negedge clk); clrQ = 1'b1;
    @(negedge clk); clrQ = 1'b0; txCnt = 0;
  endtask

  // R1 R2 R3 R4 R5 R7 R9 R11: master loopback of one or two words.
  task automatic runMaster(input logic [3:0] code, input logic [15:0] w0,
                           input logic [15:0] w1, input int n, input int div,
                           input string tag);
    int nb, waitCnt, idx;
    logic [15:0] mask;
    bit bitsOk, frmOk;
    nb = bitsOf(code);
    mask = 16'((32'd1 << nb) - 1);
    tickEn = 1'b0;
    isMaster = 1'b1;
    frameLen = code;
    clearQueues();
    txQ[0] = w0; txQ[1] = w1;
    tickDiv = div;
    txCnt = n;
    tickEn = 1'b1;
    waitCnt = 0;
    while (!(rxCnt == n && !txOe && !sclkOut) && waitCnt < 20000) begin
      @(negedge clk); waitCnt++;
    end
    repeat (4 * div + 4) @(negedge clk);
    chk(rxCnt == n, "R9", {tag, " push count"}, rxCnt, n);
    chk(rxQ[0] == (w0 & mask), "R2", {tag, " word0 loopback"}, rxQ[0], w0 & mask);
    if (n > 1)
      chk(rxQ[1] == (w1 & mask), "R2", {tag, " word1 loopback"}, rxQ[1], w1 & mask);
    chk(logN == n * (nb + 1), "R1", {tag, " rising edges"}, logN, n * (nb + 1));
    bitsOk = 1; frmOk = 1;
    for (int k = 0; k < n; k++) begin
      idx = k * (nb + 1);
      if (logFrm[idx] !== 1'b1) frmOk = 0;
      for (int b = 0; b < nb; b++) begin
        if (logFrm[idx + 1 + b] !== 1'b0) frmOk = 0;
        if (logBit[idx + 1 + b] !== ((k == 0) ? w0[nb-1-b] : w1[nb-1-b])) bitsOk = 0;
      end
    end
    chk(frmOk, "R3", {tag, " frame marker placement"}, frmOk, 1);
    chk(bitsOk, "R5", {tag, " msb-first line bits at rising edges"}, bitsOk, 1);
    chk(txIdx == n, "R11", {tag, " pops"}, txIdx, n);
    chk(!sclkOut && !frmOut && !txOe && !txd, "R4",
        {tag, " idle after drain"}, {sclkOut, frmOut, txOe, txd}, 0);
    tickEn = 1'b0;
  endtask

  // R4: master with empty queue stays quiet.
  task automatic masterEmpty();
    bit quiet;
    isMaster = 1'b1;
    clearQueues();
    tickDiv = 1; tickEn = 1'b1;
    quiet = 1;
    repeat (60) begin
      @(negedge clk);
      if (sclkOut || frmOut || txOe || txPop) quiet = 0;
    end
    chk(quiet, "R4", "empty queue no activity", quiet, 1);
    chk(logN == 0 && txIdx == 0, "R4", "empty queue edges/pops", logN + txIdx, 0);
    tickEn = 1'b0;
  endtask

  // R8 R9 R6: slave exchange at a 12-cycle bit period.
  task automatic runSlave(input logic [3:0] code, input logic [15:0] inW,
                          input logic [15:0] outW, input bit haveTx,
                          input string tag);
    int nb;
    logic [15:0] mask, got;
    bit quiet;
    nb = bitsOf(code);
    mask = 16'((32'd1 << nb) - 1);
    tickEn = 1'b0;
    isMaster = 1'b0;
    frameLen = code;
    clearQueues();
    txQ[0] = outW;
    txCnt = haveTx ? 1 : 0;
    got = '0;
    quiet = 1;
    @(negedge clk); frmIn = 1'b1;
    repeat (6) @(negedge clk); sclkIn = 1'b1;
    repeat (6) @(negedge clk); sclkIn = 1'b0; frmIn = 1'b0; sRxd = inW[nb-1];
    for (int b = 0; b < nb; b++) begin
      repeat (6) @(negedge clk);
      got = {got[14:0], txd};
      if (!txOe) quiet = 0;
      sclkIn = 1'b1;
      repeat (6) @(negedge clk);
      sclkIn = 1'b0;
      sRxd = (b + 1 < nb) ? inW[nb-2-b] : 1'b0;
    end
    repeat (8) @(negedge clk);
    chk(quiet, "R7", {tag, " slave drives data during word"}, quiet, 1);
    chk(rxCnt == 1, "R9", {tag, " slave push count"}, rxCnt, 1);
    chk(rxQ[0] == (inW & mask), "R8", {tag, " slave receive"}, rxQ[0], inW & mask);
    chk(got == (haveTx ? (outW & mask) : 16'h0), "R8", {tag, " slave transmit"},
        got, haveTx ? (outW & mask) : 0);
    chk(txIdx == (haveTx ? 1 : 0), "R8", {tag, " slave pops"}, txIdx, haveTx ? 1 : 0);
    chk(!txOe && !ctlOe && !sclkOut && !frmOut, "R6", {tag, " slave outputs off"},
        {txOe, ctlOe, sclkOut, frmOut}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R4 R7: reset values
    chk(!sclkOut && !frmOut && !txOe && !txd && !txPop && !rxPush, "R4",
        "reset outputs", {sclkOut, frmOut, txOe, txd, txPop, rxPush}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(ctlOe == 1'b1, "R6", "master enables clock/frame", ctlOe, 1);
    masterEmpty();
    runMaster(4'd15, 16'hA5C3, 16'h0, 1, 1, "m16fast");
    runMaster(4'd7, 16'h003C, 16'h00D2, 2, 3, "m8pair");
    runMaster(4'd3, 16'hFFF5, 16'h0, 1, 2, "m4junk");
    runMaster(4'd0, 16'h0009, 16'h0, 1, 1, "mclamp");
    runSlave(4'd11, 16'h0B6D, 16'h0A53, 1'b1, "s12");
    runSlave(4'd15, 16'h8001, 16'hFFFF, 1'b0, "s16empty");
    isMaster = 1'b1;
    @(negedge clk);
    chk(ctlOe == 1'b1, "R6", "back to master", ctlOe, 1);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule